// File: doc/BRIEF.md
# Framed 22-bit word serializer

This block turns a stream of 22-bit parallel words into a single-bit serial stream. A word is taken into a holding register on each strobe from the parallel clock domain. At the next frame boundary it becomes a 25-bit frame: a constant-zero guard bit, then the data with bit 0 first and bit 21 last, then two boundary bits. The frame is shifted out one bit for each serial-bit enable, so one parallel clock period spans 25 enables. The two boundary bits are both the complement of data bit 21. Every frame therefore contains at least one level change, and a receiver can find the word boundary from a pair of equal bits that follows a bit of the other value.

The block only drives the line while it is enabled and sending. While the enable input is low, or before the first word has been framed, the drive-enable flag is low and the serial bit is held at 0. A frame-start marker is high during the guard-bit slot of every frame. The line signalling, the clock multiplier and the generation of the serial-bit enable belong to the surrounding logic.

Top module: `framed_word_tx`

## Requirements
- R1: While `link_en` is high, a high `word_stb` in a clock cycle captures `word_in` into the holding register. When several strobes arrive before the held word is framed, the word from the latest strobe is the one sent.
- R2: A frame has 25 slots, and slot 0 is sent first. Slot 0 is the guard bit, slot k+1 (k = 0..21) carries `word_in[k]`, and slots 23 and 24 are the boundary bits.
- R3: The guard bit in slot 0 is always 0. `frame_start` is 1 during slot 0 and 0 in every other slot.
- R4: Both boundary bits (slots 23 and 24) equal the inverse of data bit 21 of the same word.
- R5: The frame moves forward by exactly one slot for each clock cycle with `bit_en` high. In cycles with `bit_en` low, `ser_out`, `drive_en` and `frame_start` hold their values.
- R6: A held word is loaded into the shifter only by the `bit_en` that ends slot 24, or the first `bit_en` while idle. A word captured in the middle of a frame does not disturb that frame, and its own frame follows directly after slot 24.
- R7: After reset, `drive_en`, `ser_out` and `frame_start` are 0. A `bit_en` with no captured word does nothing. The first frame begins on the first `bit_en` after the cycle of the first capture, and not on a `bit_en` in that same cycle.
- R8: If no word is held when slot 24 ends, the next `bit_en` makes the block idle: `drive_en` is 0 and `ser_out` is 0.
- R9: When `link_en` is low, `drive_en` is 0 from the next cycle on, `ser_out` is 0, any held word is discarded, and strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Enable; low powers the link down |
| word_stb | input | 1 | One-cycle strobe marking the parallel clock rising edge |
| word_in | input | 22 | Parallel data word |
| bit_en | input | 1 | Serial-bit slot enable |
| ser_out | output | 1 | Serial data bit, 0 when not driven |
| drive_en | output | 1 | Line driver enable |
| frame_start | output | 1 | High during the guard-bit slot |

## Verification
The hardest case to reach is the hand-over between frames. A new word has to be captured while the previous frame is still being sent, and must then appear without a gap after slot 24, while `bit_en` arrives at irregular intervals. The stimulus watches for `frame_start` and strobes the next word during slot 1. It gates `bit_en` at random densities so that idle cycles fall on every slot, including the last one. Directed sequences cover a strobe in the same cycle as `bit_en`, strobes that overwrite the held word, loss of `link_en` in the middle of a frame, and the underrun at the end of a stream.

// File: rtl/fwt_pkg.sv
package fwt_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/fwt_hold.sv
module fwt_hold #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              stb,
  input  logic [DATA_W-1:0] din,
  input  logic              take,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data
);
  logic              valid_d, valid_q;
  logic [DATA_W-1:0] data_d, data_q;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (!link_en) begin
      valid_d = 1'b0;
    end else if (stb) begin
      valid_d = 1'b1;
      data_d  = din;
    end else if (take) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  assign hold_valid = valid_q;
  assign hold_data  = data_q;

  // R1: an enabled strobe leaves its word in the holding register
  p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && stb) |=> (hold_valid && hold_data == $past(din)));

  // R9: disabling discards the held word
  p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_en) |=> !hold_valid);
endmodule

// File: rtl/fwt_shift.sv
module fwt_shift
  import fwt_pkg::*;
#(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              bit_en,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  output logic              load,
  output logic              ser_out,
  output logic              drive_en,
  output logic              frame_start
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_W - 1);

  function automatic logic [FRAME_W-1:0] make_frame(input logic [DATA_W-1:0] d);
    logic mark;
    mark = ~d[DATA_W-1];
    return {mark, mark, d, 1'b0};
  endfunction

  tx_state_e          state_d, state_q;
  logic [CNT_W-1:0]   slot_d, slot_q;
  logic [FRAME_W-1:0] sh_d, sh_q;
  logic               at_end;

  assign at_end = (state_q == TX_SEND) && (slot_q == LAST_SLOT);
  assign load   = link_en && bit_en && hold_valid &&
                  ((state_q == TX_IDLE) || at_end);

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    sh_d    = sh_q;
    if (!link_en) begin
      state_d = TX_IDLE;
      slot_d  = '0;
    end else if (load) begin
      state_d = TX_SEND;
      slot_d  = '0;
      sh_d    = make_frame(hold_data);
    end else if (bit_en && at_end) begin
      state_d = TX_IDLE;
      slot_d  = '0;
    end else if (bit_en && (state_q == TX_SEND)) begin
      slot_d  = slot_q + 1'b1;
      sh_d    = {1'b0, sh_q[FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      slot_q  <= '0;
      sh_q    <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      sh_q    <= sh_d;
    end
  end

  assign drive_en    = (state_q == TX_SEND);
  assign ser_out     = drive_en & sh_q[0];
  assign frame_start = drive_en && (slot_q == '0);

  // R3: guard slot is always low
  p_guard_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !ser_out);

  // R4: second boundary bit repeats the first
  p_boundary_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && slot_q == LAST_SLOT) |-> (ser_out == $past(ser_out)));

  // R5: nothing moves without a bit enable
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && !bit_en) |=> ($stable(ser_out) && $stable(drive_en) && $stable(frame_start)));

  // R7: sending starts only after an enable with a word held
  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> $past(bit_en && hold_valid));

  // R9: disabling stops the driver
  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_en) |=> !drive_en);
endmodule

// File: rtl/framed_word_tx.sv
module framed_word_tx #(
  parameter int DATA_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en,
  input  logic              word_stb,
  input  logic [DATA_W-1:0] word_in,
  input  logic              bit_en,
  output logic              ser_out,
  output logic              drive_en,
  output logic              frame_start
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              hold_valid;
  logic [DATA_W-1:0] hold_data;
  logic              load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fwt_hold #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .link_en    (link_en),
    .stb        (word_stb),
    .din        (word_in),
    .take       (load),
    .hold_valid (hold_valid),
    .hold_data  (hold_data)
  );

  fwt_shift #(.DATA_W(DATA_W)) u_shift (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .link_en     (link_en),
    .bit_en      (bit_en),
    .hold_valid  (hold_valid),
    .hold_data   (hold_data),
    .load        (load),
    .ser_out     (ser_out),
    .drive_en    (drive_en),
    .frame_start (frame_start)
  );
endmodule

// File: tb/framed_word_tx_bench.sv
module framed_word_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 22;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          link_en = 1'b0;
  logic          word_stb = 1'b0;
  logic [DW-1:0] word_in = '0;
  logic          bit_en = 1'b0;
  logic          ser_out, drive_en, frame_start;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  framed_word_tx #(.DATA_W(DW)) u_framed_word_tx (
    .clk(clk), .rst_n(rst_n), .link_en(link_en), .word_stb(word_stb),
    .word_in(word_in), .bit_en(bit_en), .ser_out(ser_out),
    .drive_en(drive_en), .frame_start(frame_start)
  );

  function automatic logic exp_bit(input logic [DW-1:0] w, input int slot);
    if (slot == 0) return 1'b0;
    if (slot <= DW) return w[slot-1];
    return ~w[DW-1];
  endfunction

  function automatic logic [DW-1:0] pattern(input int mode, input int i);
    if (mode == 0) return DW'($urandom);
    case (i % 6)
      0: return '0;
      1: return '1;
      2: return DW'(22'h155555);
      3: return DW'(22'h2AAAAA);
      4: return DW'(1) << (DW-1);
      default: return DW'(1);
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic en, input logic stb, input logic [DW-1:0] w);
    bit_en = en; word_stb = stb; word_in = w;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0; word_stb = 1'b0;
  endtask

  task automatic run_frame(input logic [DW-1:0] w, input bit later, input bit have_next,
                           input logic [DW-1:0] nxt, input int pct);
    for (int s = 0; s < DW + 3; s++) begin
      while (($urandom % 100) >= pct) begin
        tick(1'b0, 1'b0, '0);
        if (s > 0) check("R5", {31'd0, ser_out}, {31'd0, exp_bit(w, s-1)});
      end
      tick(1'b1, (s == 1) && have_next, nxt);
      check(s == 0 ? (later ? "R6" : "R3") : (s > DW ? "R4" : "R2"),
            {30'd0, drive_en, ser_out}, {30'd0, 1'b1, exp_bit(w, s)});
      check("R3", {31'd0, frame_start}, {31'd0, (s == 0)});
    end
  endtask

  task automatic stream(input int mode, input int n, input int pct);
    logic [DW-1:0] cur, nxt;
    cur = pattern(mode, 0);
    tick(1'b0, 1'b1, cur);
    for (int f = 0; f < n; f++) begin
      nxt = pattern(mode, f + 1);
      run_frame(cur, f > 0, f < n - 1, nxt, pct);
      cur = nxt;
    end
    tick(1'b1, 1'b0, '0);
    check("R8", {30'd0, drive_en, ser_out}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R7", {29'd0, drive_en, ser_out, frame_start}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    link_en = 1'b1;
    check("R7", {29'd0, drive_en, ser_out, frame_start}, 32'd0);

    tick(1'b1, 1'b0, '0);
    check("R7", {31'd0, drive_en}, 32'd0);
    tick(1'b1, 1'b1, DW'(22'h3C0F0F));
    check("R7", {31'd0, drive_en}, 32'd0);
    tick(1'b1, 1'b0, '0);
    check("R7", {30'd0, drive_en, frame_start}, 32'd3);
    tick(1'b1, 1'b0, '0);
    check("R2", {31'd0, ser_out}, {31'd0, exp_bit(DW'(22'h3C0F0F), 1)});

    link_en = 1'b0;
    tick(1'b0, 1'b0, '0);
    check("R9", {30'd0, drive_en, ser_out}, 32'd0);
    tick(1'b1, 1'b1, DW'(22'h12345));
    link_en = 1'b1;
    tick(1'b1, 1'b0, '0);
    tick(1'b1, 1'b0, '0);
    check("R9", {30'd0, drive_en, ser_out}, 32'd0);

    tick(1'b0, 1'b1, DW'(22'h0AAAAA));
    tick(1'b0, 1'b1, DW'(22'h35A5A5));
    run_frame(DW'(22'h35A5A5), 1'b0, 1'b0, '0, 100);
    tick(1'b1, 1'b0, '0);
    check("R1", {30'd0, drive_en, ser_out}, 32'd0);

    stream(1, 6, 100);
    stream(0, 8, 60);
    stream(0, 6, 25);
    stream(1, 6, 50);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
      end
    end
  end
endmodule